// File: doc/BRIEF.md
# Coherence Upgrade/Downgrade Balance Checker

This block checks, at run time, that every coherence permission gain on a block is paid for by matching permission losses elsewhere in the system. Each participating cache or memory controller drives one event port. When a transaction completes, the controller reports the block address, whether it gained or lost permission, and, on a gain, how many holders had to give something up. The block keeps one signature register per port. A gain adds the address times the downgrader count. A loss subtracts the address once. A memory controller that hands out ownership with no cache owner reports a single loss.

At an epoch boundary, the block copies every signature into a snapshot and clears the live register in the same cycle. Boundaries are placed by the system where no upgrade is half-finished. One cycle later a system-level stage adds the snapshots modulo 2^SIG_W. It raises the error flag when the total is non-zero and advances the epoch number. The verdict holds until the next boundary has been evaluated.

Top module: `coh_balance_chk`

## Requirements
- R1: While reset is asserted and after its release, err_o is 0 and epoch_o is 0 until the first boundary has been evaluated.
- R2: A valid event with kind 1 (upgrade) adds cnt × addr to its port's signature; a valid event with kind 0 (downgrade) subtracts addr; an upgrade with cnt 0 adds nothing.
- R3: If the sum of all snapshots taken at a boundary is non-zero modulo 2^SIG_W, err_o is 1. This includes an upgrade with a missing downgrade and a downgrade reported twice.
- R4: An epoch in which every upgrade with count k is matched by exactly k downgrades of the same address, on any ports, gives err_o = 0.
- R5: An event presented in the same cycle as epoch_end_i belongs to the epoch being closed.
- R6: All signatures restart from zero after a boundary, so an imbalance never carries into the next epoch's verdict.
- R7: All arithmetic wraps modulo 2^SIG_W. An imbalance that is a multiple of 2^SIG_W is not flagged.
- R8: The verdict appears in err_o exactly one cycle after the boundary cycle. In the same cycle epoch_o increments by one, modulo 2^EPOCH_W. Both outputs hold their values otherwise.
- R9: Inputs on a port whose valid bit is 0 have no effect on any verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_valid_i | input | N_COMP | Per-port event strobe |
| ev_kind_i | input | N_COMP | Per-port event kind: 1 upgrade, 0 downgrade |
| ev_addr_i | input | N_COMP × ADDR_W | Per-port block address |
| ev_cnt_i | input | N_COMP × CNT_W | Per-port downgrader count (used on upgrades) |
| epoch_end_i | input | 1 | Boundary strobe: snapshot and clear all signatures |
| err_o | output | 1 | Verdict of the last evaluated epoch (1 = imbalance) |
| epoch_o | output | EPOCH_W | Number of evaluated epochs, wrapping |

## Verification
The bench builds the block with three ports, 6-bit addresses, 2-bit counts, 8-bit signatures and a 4-bit epoch counter. With these values every address and every downgrader count can be swept in each of four epoch shapes: balanced, one downgrade missing, one downgrade doubled, and the last downgrade landing in the boundary cycle. The 8-bit signature makes modular aliasing easy to reach with a few events. The 4-bit epoch number wraps many times during the run.

// File: rtl/coh_bal_pkg.sv
package coh_bal_pkg;
  typedef enum logic {
    EV_DOWN = 1'b0,
    EV_UP   = 1'b1
  } ev_kind_e;
endpackage

// File: rtl/coh_bal_sig.sv
module coh_bal_sig
  import coh_bal_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 4,
  parameter int SIG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic              ev_kind_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic [CNT_W-1:0]  ev_cnt_i,
  input  logic              snap_i,
  output logic [SIG_W-1:0]  snap_o
);
  localparam int PROD_W = ADDR_W + CNT_W;

  logic [PROD_W-1:0] prod;
  logic [SIG_W-1:0]  prod_ext, addr_ext, delta, sig_nxt, sig_q, snap_q;

  assign prod = PROD_W'(ev_addr_i) * PROD_W'(ev_cnt_i);

  generate
    if (SIG_W > PROD_W) begin : g_prod_pad
      assign prod_ext = {{(SIG_W-PROD_W){1'b0}}, prod};
    end else begin : g_prod_cut
      assign prod_ext = prod[SIG_W-1:0];
    end
    if (SIG_W > ADDR_W) begin : g_addr_pad
      assign addr_ext = {{(SIG_W-ADDR_W){1'b0}}, ev_addr_i};
    end else begin : g_addr_cut
      assign addr_ext = ev_addr_i[SIG_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!ev_valid_i)                         delta = '0;
    else if (ev_kind_e'(ev_kind_i) == EV_UP) delta = prod_ext;
    else                                     delta = '0 - addr_ext;
    sig_nxt = sig_q + delta;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q  <= '0;
      snap_q <= '0;
    end else if (snap_i) begin
      snap_q <= sig_nxt;  // boundary-cycle event belongs to closing epoch
      sig_q  <= '0;
    end else begin
      sig_q  <= sig_nxt;
    end
  end

  assign snap_o = snap_q;

  assert_clear_on_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (sig_q == '0));

  assert_invalid_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_valid_i && !snap_i) |=> (sig_q == $past(sig_q)));

  assert_snap_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_q));
endmodule

// File: rtl/coh_bal_verdict.sv
module coh_bal_verdict #(
  parameter int N_COMP  = 4,
  parameter int SIG_W   = 32,
  parameter int EPOCH_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          eval_i,
  input  logic [N_COMP-1:0][SIG_W-1:0]  snap_i,
  output logic                          err_o,
  output logic [EPOCH_W-1:0]            epoch_o
);
  logic [SIG_W-1:0] total;

  always_comb begin
    total = '0;
    for (int i = 0; i < N_COMP; i++) total = total + snap_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o   <= 1'b0;
      epoch_o <= '0;
    end else if (eval_i) begin
      err_o   <= |total;
      epoch_o <= epoch_o + 1'b1;
    end
  end

  assert_epoch_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> (epoch_o == $past(epoch_o) + 1'b1));

  assert_verdict_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> ($stable(err_o) && $stable(epoch_o)));
endmodule

// File: rtl/coh_balance_chk.sv
module coh_balance_chk
  import coh_bal_pkg::*;
#(
  parameter int N_COMP  = 4,
  parameter int ADDR_W  = 26,
  parameter int CNT_W   = 4,
  parameter int SIG_W   = 32,
  parameter int EPOCH_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_COMP-1:0]             ev_valid_i,
  input  logic [N_COMP-1:0]             ev_kind_i,
  input  logic [N_COMP-1:0][ADDR_W-1:0] ev_addr_i,
  input  logic [N_COMP-1:0][CNT_W-1:0]  ev_cnt_i,
  input  logic                          epoch_end_i,
  output logic                          err_o,
  output logic [EPOCH_W-1:0]            epoch_o
);
  logic                         eval_q;
  logic [N_COMP-1:0][SIG_W-1:0] snap;

  generate
    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
      coh_bal_sig #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIG_W(SIG_W)) u_sig (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ev_valid_i (ev_valid_i[c]),
        .ev_kind_i  (ev_kind_i[c]),
        .ev_addr_i  (ev_addr_i[c]),
        .ev_cnt_i   (ev_cnt_i[c]),
        .snap_i     (epoch_end_i),
        .snap_o     (snap[c])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eval_q <= 1'b0;
    else         eval_q <= epoch_end_i;
  end

  coh_bal_verdict #(.N_COMP(N_COMP), .SIG_W(SIG_W), .EPOCH_W(EPOCH_W)) u_verdict (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eval_i  (eval_q),
    .snap_i  (snap),
    .err_o   (err_o),
    .epoch_o (epoch_o)
  );

  assert_eval_follows_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_end_i |=> (epoch_o == $past(epoch_o)) ##1 (epoch_o == $past(epoch_o) + 1'b1));
endmodule

// File: tb/tb_coh_balance_chk.sv
module tb_coh_balance_chk;
  localparam int N  = 3;
  localparam int AW = 6;
  localparam int CW = 2;
  localparam int SW = 8;
  localparam int EW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         valid, kind;
  logic [N-1:0][AW-1:0] addr;
  logic [N-1:0][CW-1:0] cnt;
  logic                 eend;
  logic                 err;
  logic [EW-1:0]        epoch;

  int n_chk = 0, n_bad = 0, cyc = 0, ep_exp = 0;
  bit prev_err = 0;

  always #2 clk = ~clk;

  coh_balance_chk #(.N_COMP(N), .ADDR_W(AW), .CNT_W(CW), .SIG_W(SW), .EPOCH_W(EW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(valid), .ev_kind_i(kind),
    .ev_addr_i(addr), .ev_cnt_i(cnt), .epoch_end_i(eend), .err_o(err), .epoch_o(epoch));

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
      report();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // idle ports carry junk with valid low (R9)
  task automatic idle;
    valid = '0;
    for (int c = 0; c < N; c++) begin
      kind[c] = 1'b1; addr[c] = '1; cnt[c] = '1;
    end
  endtask

  task automatic ev(input int c, input bit up, input int a, input int k);
    valid[c] = 1'b1; kind[c] = up; addr[c] = AW'(a); cnt[c] = CW'(k);
  endtask

  // boundary; last_in_boundary: events already set stay in the boundary cycle (R5)
  task automatic close_epoch(input bit last_in_boundary, input int exp_sum, input string req);
    if (!last_in_boundary) idle();
    eend = 1'b1;
    @(negedge clk);
    idle(); eend = 1'b0;
    @(negedge clk);
    ep_exp = (ep_exp + 1) % (1 << EW);
    check(req, int'(err), ((exp_sum % (1 << SW)) != 0) ? 1 : 0);
    check("R8", int'(epoch), ep_exp);
    prev_err = err;
  endtask

  // mode 0 balanced, 1 missing downgrade, 2 doubled downgrade, 3 last downgrade in boundary cycle
  task automatic run_epoch(input int u, input int a, input int k, input int mode);
    int nd, s;
    string req;
    nd = (mode == 1) ? ((k > 0) ? k - 1 : 0) : (mode == 2) ? k + 1 : k;
    s  = k * a - nd * a;
    if (s < 0) s = s + (1 << SW) * 8;
    req = (mode == 3) ? "R5" : (mode == 0) ? (prev_err ? "R6" : "R4") : "R3";
    @(negedge clk); idle(); ev(u, 1'b1, a, k);
    for (int j = 0; j < nd; j++) begin
      if (mode == 3 && j == nd - 1) break;
      @(negedge clk); idle(); ev((u + 1 + j) % N, 1'b0, a, 0);
    end
    @(negedge clk);
    idle();
    if (mode == 3 && nd > 0) ev((u + nd) % N, 1'b0, a, 0);
    close_epoch(mode == 3 && nd > 0, s, req);
  endtask

  initial begin
    idle(); eend = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(err), 0);
    check("R1", int'(epoch), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", int'(err), 0);
    check("R1", int'(epoch), 0);

    // R2: lone upgrade with count 0 adds nothing; lone upgrade k=1 is imbalance
    @(negedge clk); ev(1, 1'b1, 37, 0);
    @(negedge clk); close_epoch(1'b0, 0, "R2");
    @(negedge clk); ev(2, 1'b1, 5, 1);
    @(negedge clk); close_epoch(1'b0, 5, "R2");
    // R6: following empty epoch is clean
    @(negedge clk); close_epoch(1'b0, 0, "R6");

    // R7: 4 x (2*32) = 256 wraps to zero; 3 x = 192 flagged
    for (int r = 0; r < 4; r++) begin @(negedge clk); idle(); ev(0, 1'b1, 32, 2); end
    @(negedge clk); close_epoch(1'b0, 256, "R7");
    for (int r = 0; r < 3; r++) begin @(negedge clk); idle(); ev(0, 1'b1, 32, 2); end
    @(negedge clk); close_epoch(1'b0, 192, "R7");

    // memory as sole downgrader: upgrade k=1 on port 0, memory port 2 downgrades
    @(negedge clk); idle(); ev(0, 1'b1, 44, 1); ev(2, 1'b0, 44, 0);
    @(negedge clk); close_epoch(1'b0, 0, "R4");

    // R9: only invalid traffic for several cycles
    repeat (5) @(negedge clk);
    close_epoch(1'b0, 0, "R9");

    for (int a = 0; a < (1 << AW); a++)
      for (int k = 0; k < (1 << CW); k++)
        for (int m = 0; m < 4; m++)
          run_epoch(a % N, a, k, m);

    report();
  end
endmodule